// File: doc/BRIEF.md
# Comparator Event Interrupt Controller

This block is the control and status register that sits beside a comparator. The comparator's result arrives here as a one-bit digital level. Software reaches the block through one 8-bit register, which it can read and write at a single I/O address. The register selects which transition of the comparator result counts as an event. When an event happens, the block latches an interrupt flag and raises a request toward the interrupt controller. The request is gated by a local enable and by the processor's global interrupt enable.

The flag can be cleared in two ways. Hardware clears it when the interrupt vector acknowledges the request. Software clears it by writing a one to the flag's bit. Three further register bits drive outputs that leave the block:
- a power-down line for the comparator;
- a select line that picks between the external pin and the internal reference as the comparator's positive input;
- a gate that forwards the comparator result to a timer's capture input.

The comparator result is asynchronous. It passes through a two-flop synchronizer, and a registered copy of the synchronized level is kept so that edges can be detected. While the power-down bit is set, the block detects no events. During that time the registered copy keeps following the input, so clearing the power-down bit later does not create a false edge.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: After reset, all stored register bits read 0, and `irq_req`, `pwr_down`, `ref_sel` and `cap_trig` are all 0.
- R2: A write stores `reg_wdata` bits 7, 6, 3, 2, 1 and 0 into the same register positions, and they read back unchanged. A write to bit 5 or bit 4 stores nothing.
- R3: Register bit 5 reads the synchronized comparator level. After the input changes, bit 5 still shows the old value after one rising clock edge and shows the new value after the second.
- R4: The mode field (bits 1:0) selects what counts as an event: 00 is any change, 01 is no event, 10 is a falling edge, 11 is a rising edge. A matching input change sets the flag (bit 4). The flag is visible after the third rising edge that follows the input change and is not yet visible after the second.
- R5: A one-cycle pulse on `irq_ack` clears the flag. If an event happens in the same cycle, the flag stays set.
- R6: Writing a 1 to bit 4 clears the flag, and writing a 0 there leaves it unchanged. If an event happens in the same cycle as the clearing write, the flag stays set.
- R7: `irq_req` is 1 exactly when the flag, the enable bit (bit 3) and `glb_irq_en` are all 1.
- R8: `ref_sel` equals bit 6. A value of 1 selects the internal reference and 0 selects the external pin.
- R9: `cap_trig` equals the synchronized comparator level when bit 2 is 1, and is 0 when bit 2 is 0.
- R10: `pwr_down` equals bit 7. While bit 7 is 1, no input change sets the flag. Clearing bit 7 creates no event, and edge detection resumes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| cmp_in | input | 1 | Asynchronous comparator result |
| irq_ack | input | 1 | Vector-taken acknowledge, one cycle |
| glb_irq_en | input | 1 | Global interrupt enable |
| irq_req | output | 1 | Interrupt request |
| ref_sel | output | 1 | Positive-input select, 1 = internal reference |
| pwr_down | output | 1 | Comparator power-down |
| cap_trig | output | 1 | Comparator level forwarded to the timer capture input |

## Verification
The checker examines several properties on every cycle:
- the request is never high without its three qualifiers;
- the flag never changes unless an event or a clearing source is present;
- each clearing source takes effect one edge later;
- no event is detected while the comparator is powered down;
- written control bits appear on the outputs one edge later.

Some behaviour only the bench scenarios can show:
- that the four mode codes pick the right edges;
- the two-edge and three-edge latencies;
- that an event takes precedence over a clear in the same cycle;
- that clearing the power-down bit leaves no false edge.

// File: rtl/cmp_irq_pkg.sv
// Package: shared constants and the event-mode type for the comparator
// interrupt controller. Assumes an 8-bit register whose bit positions are
// fixed, because software decodes them.
package cmp_irq_pkg;
    localparam int REG_W    = 8;
    localparam int B_PWRDN  = 7;
    localparam int B_REFSEL = 6;
    localparam int B_LEVEL  = 5;
    localparam int B_FLAG   = 4;
    localparam int B_IE     = 3;
    localparam int B_CAPEN  = 2;
    localparam int MODE_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        EVT_ANY  = 2'b00,
        EVT_NONE = 2'b01,
        EVT_FALL = 2'b10,
        EVT_RISE = 2'b11
    } evt_mode_e;
endpackage

// File: rtl/cmp_sync_edge.sv
// Module: synchronizes the asynchronous comparator level through STAGES
// flops and keeps one registered copy of the result, so that rising and
// falling edges can be reported. When hold is 1, no edge is reported, but
// the copy keeps following the input.
// Assumes STAGES >= 2.
module cmp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic hold,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // First synchronizer flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
    end

    // Remaining synchronizer flops.
    for (genvar g = 1; g < STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
        end
    end

    assign level = chain[STAGES-1];

    // Previous-level copy, updated every cycle, including while hold is 1.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= level;
    end

    // Edge decode, suppressed while hold is 1.
    always_comb begin
        rise = !hold &&  level && !prev;
        fall = !hold && !level &&  prev;
    end
endmodule

// File: rtl/cmp_evt_sel.sv
// Module: turns the detected edges into one event pulse, according to the
// mode field. Purely combinational.
module cmp_evt_sel
    import cmp_irq_pkg::*;
(
    input  evt_mode_e mode,
    input  logic      rise,
    input  logic      fall,
    output logic      hit
);
    // Pick which edge kinds count as an event.
    always_comb begin
        unique case (mode)
            EVT_ANY:  hit = rise | fall;
            EVT_NONE: hit = 1'b0;
            EVT_FALL: hit = fall;
            EVT_RISE: hit = rise;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmp_irq_flag.sv
// Module: the sticky interrupt flag. It is set by an event and cleared by
// the vector acknowledge or by a software write of one. When set and clear
// arrive in the same cycle, set wins, so no event is lost.
module cmp_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    input  logic sw_clr_i,
    output logic flag_o
);
    // Update the flag: set has priority over both clear sources.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (ack_i || sw_clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/cmp_irq_ctrl.sv
// Module: top of the comparator interrupt controller.
// - Holds the control bits and assembles the read-back register.
// - Drives the power-down, reference-select and capture-trigger outputs.
// - Gates the interrupt request.
// Assumes writes arrive on a one-cycle strobe and that reads are
// combinational from the register state.
module cmp_irq_ctrl
    import cmp_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             cmp_in,
    input  logic             irq_ack,
    input  logic             glb_irq_en,
    output logic             irq_req,
    output logic             ref_sel,
    output logic             pwr_down,
    output logic             cap_trig
);
    logic      pd_q, ref_q, ie_q, cap_q;
    evt_mode_e mode_q;
    logic      level, rise, fall, evt_hit, flag;
    logic      sw_clr;

    // Control bits: writable fields only; bits 5 and 4 are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q   <= 1'b0;
            ref_q  <= 1'b0;
            ie_q   <= 1'b0;
            cap_q  <= 1'b0;
            mode_q <= EVT_ANY;
        end else if (reg_wr_en) begin
            pd_q   <= reg_wdata[B_PWRDN];
            ref_q  <= reg_wdata[B_REFSEL];
            ie_q   <= reg_wdata[B_IE];
            cap_q  <= reg_wdata[B_CAPEN];
            mode_q <= evt_mode_e'(reg_wdata[MODE_W-1:0]);
        end
    end

    cmp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cmp_in), .hold(pd_q),
        .level(level), .rise(rise), .fall(fall)
    );

    cmp_evt_sel u_sel (
        .mode(mode_q), .rise(rise), .fall(fall), .hit(evt_hit)
    );

    assign sw_clr = reg_wr_en && reg_wdata[B_FLAG];

    cmp_irq_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(evt_hit), .ack_i(irq_ack),
        .sw_clr_i(sw_clr), .flag_o(flag)
    );

    // Read-back register and block outputs.
    always_comb begin
        reg_rdata = {pd_q, ref_q, level, flag, ie_q, cap_q, mode_q};
        irq_req   = flag && ie_q && glb_irq_en;
        ref_sel   = ref_q;
        pwr_down  = pd_q;
        cap_trig  = cap_q && level;
    end
endmodule

// File: rtl/cmp_irq_chk.sv
// Checker: cycle-by-cycle properties of the comparator interrupt
// controller. It is attached to every instance of the top module by bind.
module cmp_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_en,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       irq_ack,
    input logic       glb_irq_en,
    input logic       irq_req,
    input logic       ref_sel,
    input logic       pwr_down,
    input logic       cap_trig,
    input logic       evt_hit
);
    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (glb_irq_en && reg_rdata[4] && reg_rdata[3]));

    assert_evt_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_hit |=> reg_rdata[4]);

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !evt_hit) |=> !reg_rdata[4]);

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wdata[4] && !evt_hit) |=> !reg_rdata[4]);

    assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_hit && !irq_ack && !(reg_wr_en && reg_wdata[4]))
            |=> $stable(reg_rdata[4]));

    assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (reg_rdata[3:0] == $past(reg_wdata[3:0])));

    assert_ref_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (ref_sel == $past(reg_wdata[6])));

    assert_pwr_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (pwr_down == $past(reg_wdata[7])));

    assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !evt_hit);

    assert_cap_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_trig |-> (reg_rdata[2] && reg_rdata[5]));
endmodule

bind cmp_irq_ctrl cmp_irq_chk i_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_ack(irq_ack), .glb_irq_en(glb_irq_en),
    .irq_req(irq_req), .ref_sel(ref_sel), .pwr_down(pwr_down),
    .cap_trig(cap_trig), .evt_hit(evt_hit)
);

// File: tb/test_cmp_irq_ctrl.sv
// Bench for cmp_irq_ctrl. It sweeps every mode, both edge directions and
// all gating combinations, and computes the expected values from the mode
// encoding.
module test_cmp_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cmp_in = 1'b0;
    logic       irq_ack = 1'b0;
    logic       glb_irq_en = 1'b0;
    logic       irq_req, ref_sel, pwr_down, cap_trig;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    cmp_irq_ctrl i_cmp_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cmp_in(cmp_in), .irq_ack(irq_ack),
        .glb_irq_en(glb_irq_en), .irq_req(irq_req), .ref_sel(ref_sel),
        .pwr_down(pwr_down), .cap_trig(cap_trig)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wr_en = 1'b1;
        reg_wdata = v;
        tick(1);
        reg_wr_en = 1'b0;
        reg_wdata = 8'h00;
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 outs", {4'h0, irq_req, pwr_down, ref_sel, cap_trig}, 8'h00);

        // R2: stored bits, and bits 5/4 not stored; R8 / R10 output follow
        wr(8'hCF);
        chk("R2 store", reg_rdata, 8'hCF);
        chk("R8 ref_sel", {7'h0, ref_sel}, 8'h01);
        chk("R10 pwr_down", {7'h0, pwr_down}, 8'h01);
        wr(8'h30);
        chk("R2 ro bits", reg_rdata, 8'h00);
        chk("R8 ref_sel ext", {7'h0, ref_sel}, 8'h00);

        // R4 / R5 / R6 / R7: sweep over mode, direction and gating
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 2; d++) begin
                logic exp;
                exp = (m == 0) || (m == 2 && d == 0) || (m == 3 && d == 1);
                wr(8'h01);
                cmp_in = ~d[0];
                tick(3);
                wr(8'h11);
                chk("R6 clear base", {7'h0, reg_rdata[4]}, 8'h00);
                wr(8'h08 | m[7:0]);
                cmp_in = d[0];
                tick(2);
                chk("R4 not yet", {7'h0, reg_rdata[4]}, 8'h00);
                tick(1);
                chk("R4 mode flag", {7'h0, reg_rdata[4]}, {7'h0, exp});
                for (int g = 0; g < 2; g++) begin
                    glb_irq_en = g[0];
                    #1;
                    chk("R7 irq gate", {7'h0, irq_req}, {7'h0, exp & g[0]});
                end
                wr(m[7:0]);
                chk("R7 ie off", {7'h0, irq_req}, 8'h00);
                chk("R6 write zero", {7'h0, reg_rdata[4]}, {7'h0, exp});
                if (d == 1) ack_pulse();
                else        wr(8'h10 | m[7:0]);
                chk("R5/R6 cleared", {7'h0, reg_rdata[4]}, 8'h00);
                glb_irq_en = 1'b0;
            end
        end

        // R3: level latency (input is 1 here)
        cmp_in = 1'b0;
        tick(1);
        chk("R3 old level", {7'h0, reg_rdata[5]}, 8'h01);
        tick(1);
        chk("R3 new level", {7'h0, reg_rdata[5]}, 8'h00);

        // R9: capture gate
        wr(8'h05);
        chk("R9 low level", {7'h0, cap_trig}, 8'h00);
        cmp_in = 1'b1;
        tick(2);
        chk("R9 forward", {7'h0, cap_trig}, 8'h01);
        wr(8'h01);
        chk("R9 gated", {7'h0, cap_trig}, 8'h00);

        // R10: disable suppresses events; re-enable makes no false edge
        wr(8'h11);
        wr(8'h80);
        cmp_in = 1'b0;
        tick(3);
        chk("R10 suppressed", {7'h0, reg_rdata[4]}, 8'h00);
        wr(8'h00);
        tick(3);
        chk("R10 no false edge", {7'h0, reg_rdata[4]}, 8'h00);
        cmp_in = 1'b1;
        tick(3);
        chk("R10 resumes", {7'h0, reg_rdata[4]}, 8'h01);
        ack_pulse();

        // R5: event beats ack in the same cycle
        cmp_in = 1'b0;
        tick(2);
        ack_pulse();
        chk("R5 set wins", {7'h0, reg_rdata[4]}, 8'h01);
        // R6: event beats the clearing write in the same cycle
        wr(8'h10);
        cmp_in = 1'b1;
        tick(2);
        wr(8'h10);
        chk("R6 set wins", {7'h0, reg_rdata[4]}, 8'h01);
        wr(8'h10);
        chk("R6 final clear", {7'h0, reg_rdata[4]}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule